// File: doc/BRIEF.md
# Nibble-Wide Multiplexed Bus Master

This block is the host side of a narrow peripheral bus that carries addresses and data over the same four wires. It has three active-low strobes: one loads an address, one reads and one writes. A client asks for a burst of one to sixteen nibbles at a starting register address. The block sends that address once. It then issues one read or write strobe per nibble and relies on the peripheral to advance its own register pointer after each strobe. Write nibbles come in through a valid/ready input. Read nibbles come out one per cycle, each marked with a valid pulse.

The block also watches the peripheral's active-low key-change interrupt. When the line is low and no command is running, the block runs a service sequence of its own. The sequence loads key register 0xA and reads two nibbles back to back. The second read, at 0xB, makes the peripheral release the interrupt. The block then presents the seven-bit key vector with a single-cycle pulse.

Every protocol step (address, strobe low, strobe released) lasts a fixed number of clocks, set by a parameter that must be at least one.

Top module: `nibble_bus_master`

## Requirements
- R1: During and after the synchronous active-high reset, all three strobes are high, the master does not drive the bus, `busy` is low and `cmdReady` is high while `intrN` is high.
- R2: Each command starts with one address step. In that step `ldaN` is low for exactly STEP_CLKS clocks and the bus carries the command address.
- R3: In a write, each nibble is taken on a `wrValid`/`wrReady` handshake. `wrN` is then low for exactly STEP_CLKS clocks, and the master drives that nibble, held stable, throughout. While `wrValid` stays low, no write strobe is issued and the master stays busy.
- R4: In a read, `rdN` is low for exactly STEP_CLKS clocks and the master releases the bus. The value on the bus in the last low clock appears on `rdData`, with `rdValid` high for one cycle, in the first clock after `rdN` returns high.
- R5: `cmdLen` encodes the nibble count minus one (0 gives 1 nibble, 15 gives 16). A command issues exactly that many strobes after its single address step, with no further address phase. Consecutive read strobes are separated by exactly STEP_CLKS high clocks. The bus pointer wraps modulo 16.
- R6: At most one of `ldaN`, `rdN`, `wrN` is low at a time. The master never drives the bus while `rdN` is low.
- R7: `busy` is high from the cycle after a command or service is accepted until its last release step ends. All strobes are idle while `busy` is low. `cmdReady` is high only when idle with `intrN` high. `cmdWrite` = 1 selects a write.
- R8: With `intrN` low while idle, the block loads address 0xA and performs two reads. Register 0xA supplies keys 6..4 in its bits 2..0, and its bit 3 reads as 1. Register 0xB supplies keys 3..0. The block presents `keyVec` = {keys 6..4, keys 3..0} with a one-cycle `keyValid`, and raises no `rdValid` for these reads.
- R9: An interrupt that arrives during a burst does not interrupt it. The service runs after the burst completes and before the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command accepted this cycle when high with cmdValid |
| cmdAddr | input | 4 | Starting register address |
| cmdLen | input | 4 | Nibble count minus one |
| cmdWrite | input | 1 | 1 = write burst, 0 = read burst |
| wrValid | input | 1 | Write nibble available |
| wrReady | output | 1 | Write nibble taken this cycle |
| wrData | input | 4 | Write nibble |
| rdValid | output | 1 | One-cycle pulse per read nibble |
| rdData | output | 4 | Read nibble |
| keyValid | output | 1 | One-cycle pulse when a key vector is fetched |
| keyVec | output | 7 | Fetched key states |
| busy | output | 1 | Transaction in progress |
| intrN | input | 1 | Peripheral interrupt, active low |
| ldaN | output | 1 | Address load strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| da | inout | 4 | Multiplexed address/data bus |

## Verification
The bench builds the block with STEP_CLKS = 3. Every strobe then spans several clocks, so width checks separate a one-clock step from a correct one. The bench can also see the gap between read strobes and observe that the write nibble holds steady through a strobe. With this setting a burst is long enough for a key interrupt to be injected in its middle. A sixteen-nibble read starting at 0x8 exercises pointer wrap-around and the key registers under normal reads.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_FETCH,
    ST_STROBE,
    ST_RELEASE
  } nbmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;     // latch a client command
    logic loadKey;     // latch the key-service command
    logic latchWr;     // take a write nibble
    logic addrPhase;   // address step active
    logic strobePhase; // read/write strobe step active
    logic timed;       // a step timer is running
    logic capture;     // sample the bus at the end of a read strobe
    logic advance;     // move on to the next nibble
  } nbmCtl_t;

endpackage

// File: rtl/nbm_ctrl.sv
module nbm_ctrl
  import nbm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmdValid,
  input  logic    wrValid,
  input  logic    intrN,
  input  logic    isWrite,
  input  logic    lastNibble,
  input  logic    stepDone,
  output logic    cmdReady,
  output logic    wrReady,
  output logic    busy,
  output nbmCtl_t ctl
);

  nbmState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    cmdReady  = 1'b0;
    wrReady   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!intrN) begin
          ctl.loadKey = 1'b1;
          stateNext   = ST_ADDR;
        end else begin
          cmdReady = 1'b1;
          if (cmdValid) begin
            ctl.loadCmd = 1'b1;
            stateNext   = ST_ADDR;
          end
        end
      end
      ST_ADDR: begin
        ctl.addrPhase = 1'b1;
        ctl.timed     = 1'b1;
        if (stepDone) stateNext = isWrite ? ST_FETCH : ST_STROBE;
      end
      ST_FETCH: begin
        wrReady = 1'b1;
        if (wrValid) begin
          ctl.latchWr = 1'b1;
          stateNext   = ST_STROBE;
        end
      end
      ST_STROBE: begin
        ctl.strobePhase = 1'b1;
        ctl.timed       = 1'b1;
        if (stepDone) begin
          ctl.capture = !isWrite;
          stateNext   = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        ctl.timed = 1'b1;
        if (stepDone) begin
          if (lastNibble) begin
            stateNext = ST_IDLE;
          end else begin
            ctl.advance = 1'b1;
            stateNext   = isWrite ? ST_FETCH : ST_STROBE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/nbm_dpath.sv
module nbm_dpath
  import nbm_pkg::*;
#(
  parameter int          STEP_CLKS = 1,
  parameter int          DW        = 4,
  parameter int          LW        = 4,
  parameter int          KEY_W     = 7,
  parameter logic [3:0]  KEY_ADDR  = 4'hA
) (
  input  logic             clk,
  input  logic             rst,
  input  nbmCtl_t          ctl,
  input  logic [DW-1:0]    cmdAddr,
  input  logic [LW-1:0]    cmdLen,
  input  logic             cmdWrite,
  input  logic [DW-1:0]    wrData,
  input  logic [DW-1:0]    daIn,
  output logic             isWrite,
  output logic             lastNibble,
  output logic             stepDone,
  output logic             ldaN,
  output logic             rdN,
  output logic             wrN,
  output logic [DW-1:0]    daOut,
  output logic             daDrive,
  output logic             rdValid,
  output logic [DW-1:0]    rdData,
  output logic             keyValid,
  output logic [KEY_W-1:0] keyVec
);

  localparam int SCW      = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam int KEY_HI_W = KEY_W - DW;
  localparam logic [SCW-1:0] STEP_LAST = SCW'(STEP_CLKS - 1);

  logic [DW-1:0]       curAddr;
  logic [LW-1:0]       lenR;
  logic [LW-1:0]       cnt;
  logic                keySvc;
  logic [DW-1:0]       wrLatch;
  logic [SCW-1:0]      stepCnt;
  logic [KEY_HI_W-1:0] keyHi;

  assign stepDone   = (stepCnt == STEP_LAST);
  assign lastNibble = (cnt == lenR);

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      lenR     <= '0;
      cnt      <= '0;
      isWrite  <= 1'b0;
      keySvc   <= 1'b0;
      wrLatch  <= '0;
      stepCnt  <= '0;
      keyHi    <= '0;
      keyVec   <= '0;
      keyValid <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid  <= 1'b0;
      keyValid <= 1'b0;
      if (ctl.loadCmd) begin
        curAddr <= cmdAddr;
        lenR    <= cmdLen;
        isWrite <= cmdWrite;
        keySvc  <= 1'b0;
        cnt     <= '0;
      end
      if (ctl.loadKey) begin
        curAddr <= KEY_ADDR;
        lenR    <= LW'(1);
        isWrite <= 1'b0;
        keySvc  <= 1'b1;
        cnt     <= '0;
      end
      if (ctl.latchWr) wrLatch <= wrData;
      if (ctl.timed) stepCnt <= stepDone ? '0 : stepCnt + SCW'(1);
      else           stepCnt <= '0;
      if (ctl.capture) begin
        if (keySvc) begin
          if (cnt == '0) begin
            keyHi <= daIn[KEY_HI_W-1:0];
          end else begin
            keyVec   <= {keyHi, daIn};
            keyValid <= 1'b1;
          end
        end else begin
          rdData  <= daIn;
          rdValid <= 1'b1;
        end
      end
      if (ctl.advance) cnt <= cnt + LW'(1);
    end
  end

  // pin decode
  assign ldaN    = ~ctl.addrPhase;
  assign rdN     = ~(ctl.strobePhase & ~isWrite);
  assign wrN     = ~(ctl.strobePhase & isWrite);
  assign daDrive = ctl.addrPhase | (ctl.strobePhase & isWrite);
  assign daOut   = ctl.addrPhase ? curAddr : wrLatch;

endmodule

// File: rtl/nibble_bus_master.sv
module nibble_bus_master
  import nbm_pkg::*;
#(
  parameter int STEP_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic [3:0] cmdAddr,
  input  logic [3:0] cmdLen,
  input  logic       cmdWrite,
  input  logic       wrValid,
  output logic       wrReady,
  input  logic [3:0] wrData,
  output logic       rdValid,
  output logic [3:0] rdData,
  output logic       keyValid,
  output logic [6:0] keyVec,
  output logic       busy,
  input  logic       intrN,
  output logic       ldaN,
  output logic       rdN,
  output logic       wrN,
  inout  wire  [3:0] da
);

  nbmCtl_t    ctl;
  logic       isWrite;
  logic       lastNibble;
  logic       stepDone;
  logic [3:0] daOut;
  logic       daDrive;
  logic [3:0] daIn;

  assign da   = daDrive ? daOut : 4'bz;
  assign daIn = da;

  nbm_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdValid   (cmdValid),
    .wrValid    (wrValid),
    .intrN      (intrN),
    .isWrite    (isWrite),
    .lastNibble (lastNibble),
    .stepDone   (stepDone),
    .cmdReady   (cmdReady),
    .wrReady    (wrReady),
    .busy       (busy),
    .ctl        (ctl)
  );

  nbm_dpath #(
    .STEP_CLKS (STEP_CLKS),
    .DW        (4),
    .LW        (4),
    .KEY_W     (7),
    .KEY_ADDR  (4'hA)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .cmdAddr    (cmdAddr),
    .cmdLen     (cmdLen),
    .cmdWrite   (cmdWrite),
    .wrData     (wrData),
    .daIn       (daIn),
    .isWrite    (isWrite),
    .lastNibble (lastNibble),
    .stepDone   (stepDone),
    .ldaN       (ldaN),
    .rdN        (rdN),
    .wrN        (wrN),
    .daOut      (daOut),
    .daDrive    (daDrive),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .keyValid   (keyValid),
    .keyVec     (keyVec)
  );

endmodule

// File: rtl/nbm_checker.sv
module nbm_checker (
  input logic       clk,
  input logic       rst,
  input logic       ldaN,
  input logic       rdN,
  input logic       wrN,
  input logic       daDrive,
  input logic [3:0] da,
  input logic       busy,
  input logic       cmdReady,
  input logic       intrN,
  input logic       rdValid,
  input logic       keyValid
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~ldaN, ~rdN, ~wrN}) <= 1); // R6

  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> !daDrive); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ldaN && rdN && wrN && !daDrive)); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmdReady |-> (!busy && intrN)); // R7

  AST_ADDR_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(ldaN) |-> !$past(busy)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wrN && $past(!wrN)) |-> $stable(da)); // R3

  AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $rose(rdN)); // R4

  AST_KEY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> $rose(rdN)); // R8

endmodule

bind nibble_bus_master nbm_checker u_nbm_checker (
  .clk      (clk),
  .rst      (rst),
  .ldaN     (ldaN),
  .rdN      (rdN),
  .wrN      (wrN),
  .daDrive  (daDrive),
  .da       (da),
  .busy     (busy),
  .cmdReady (cmdReady),
  .intrN    (intrN),
  .rdValid  (rdValid),
  .keyValid (keyValid)
);

// File: tb/tb_nibble_bus_master.sv
module tb_nibble_bus_master;

  localparam int STEP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic       cmdValid, cmdReady, cmdWrite;
  logic [3:0] cmdAddr, cmdLen;
  logic       wrValid, wrReady;
  logic [3:0] wrData;
  logic       rdValid, keyValid, busy;
  logic [3:0] rdData;
  logic [6:0] keyVec;
  logic       intrN, ldaN, rdN, wrN;
  wire  [3:0] da;

  nibble_bus_master #(.STEP_CLKS(STEP)) dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdWrite(cmdWrite),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .keyValid(keyValid), .keyVec(keyVec),
    .busy(busy), .intrN(intrN), .ldaN(ldaN), .rdN(rdN), .wrN(wrN), .da(da)
  );

  // behavioural peripheral
  logic [3:0] pmem [0:9];
  logic [3:0] ptr;
  logic [6:0] keys, keysNext;
  logic       prevWr, prevRd;
  logic [3:0] pVal;

  always_comb begin
    if (ptr < 4'd10)       pVal = pmem[ptr];
    else if (ptr == 4'hA)  pVal = {1'b1, keys[6:4]};
    else if (ptr == 4'hB)  pVal = keys[3:0];
    else                   pVal = 4'h0;
  end
  assign da = rdN ? 4'bz : pVal;

  always @(posedge clk) begin
    if (rst) begin
      ptr    <= 4'h0;
      intrN  <= 1'b1;
      prevWr <= 1'b1;
      prevRd <= 1'b1;
      keys   <= 7'h7F;
      for (int i = 0; i < 10; i++) pmem[i] <= 4'h0;
    end else begin
      prevWr <= wrN;
      prevRd <= rdN;
      if (keysNext != keys) begin
        keys  <= keysNext;
        intrN <= 1'b0;
      end else if (!rdN && ptr == 4'hB) begin
        intrN <= 1'b1;
      end
      if (!ldaN) ptr <= da;
      else if ((wrN && !prevWr) || (rdN && !prevRd)) ptr <= ptr + 4'h1;
      else if (!wrN && ptr < 4'd10) pmem[ptr] <= da;
    end
  end

  // bench bookkeeping
  int errors = 0;
  int checks = 0;
  logic [3:0] shadow [0:9];
  logic [3:0] rdQ [$];
  logic [3:0] wrQ [$];
  logic [3:0] ldaQ [$];
  int rdCount = 0, keyCount = 0, keyAtRd = 0;
  int ldaFalls = 0, rdFalls = 0, wrFalls = 0;
  logic wrStall = 1'b0;
  logic wrTaken = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expVal(input logic [3:0] a);
    if (a < 4'd10)      return shadow[a];
    else if (a == 4'hA) return {1'b1, keysNext[6:4]};
    else if (a == 4'hB) return keysNext[3:0];
    else                return 4'h0;
  endfunction

  // write data feeder
  always @(posedge clk) wrTaken <= wrValid && wrReady;
  always @(negedge clk) begin
    if (wrTaken && wrQ.size() > 0) void'(wrQ.pop_front());
    wrValid = (wrQ.size() > 0) && !wrStall;
    wrData  = (wrQ.size() > 0) ? wrQ[0] : 4'h0;
  end

  // monitor sampled at the falling edge
  int ldaRun = 0, rdRun = 0, wrRun = 0, rdGap = 0;
  bit rdGapValid = 0;
  logic [3:0] ldaSeen = 4'h0;
  logic [3:0] wrSeen = 4'h0;
  logic mLda = 1'b1, mRd = 1'b1, mWr = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ldaN) begin
        ldaRun++;
        ldaSeen = da;
      end
      if (!ldaN && mLda) begin
        ldaFalls++;
        rdGapValid = 0;
        chk(rdN && wrN, "R6", "other strobe low at address", {rdN, wrN}, 3);
      end
      if (ldaN && !mLda) begin
        chk(ldaRun == STEP, "R2", "address step width", ldaRun, STEP);
        if (ldaQ.size() > 0) begin
          chk(ldaSeen == ldaQ[0], "R2", "address nibble", ldaSeen, ldaQ[0]);
          void'(ldaQ.pop_front());
        end else chk(0, "R2", "unexpected address phase", ldaSeen, 0);
        ldaRun = 0;
      end
      if (!rdN) rdRun++;
      else if (mRd) rdGap++;
      if (!rdN && mRd) begin
        rdFalls++;
        chk(ldaN && wrN, "R6", "other strobe low at read", {ldaN, wrN}, 3);
        chk(da == pVal, "R6", "bus value during read", da, pVal);
        if (rdGapValid) chk(rdGap == STEP, "R5", "read release width", rdGap, STEP);
      end
      if (rdN && !mRd) begin
        chk(rdRun == STEP, "R4", "read strobe width", rdRun, STEP);
        rdRun = 0;
        rdGap = 1;
        rdGapValid = 1;
      end
      if (!wrN) begin
        wrRun++;
        wrSeen = da;
      end
      if (!wrN && mWr) begin
        wrFalls++;
        chk(ldaN && rdN, "R6", "other strobe low at write", {ldaN, rdN}, 3);
      end
      if (wrN && !mWr) begin
        chk(wrRun == STEP, "R3", "write strobe width", wrRun, STEP);
        wrRun = 0;
      end
      if (rdValid) begin
        rdCount++;
        if (rdQ.size() > 0) begin
          chk(rdData == rdQ[0], "R4", "read nibble", rdData, rdQ[0]);
          void'(rdQ.pop_front());
        end else chk(0, "R4", "unexpected read pulse", rdData, 0);
      end
      if (keyValid) begin
        keyCount++;
        keyAtRd = rdCount;
        chk(keyVec == keysNext, "R8", "key vector", keyVec, keysNext);
      end
      mLda = ldaN;
      mRd  = rdN;
      mWr  = wrN;
    end
  end

  task automatic doCmd(input logic [3:0] a, input logic [3:0] len, input bit wr,
                       input logic [3:0] d0 = 0, input logic [3:0] d1 = 0);
    ldaQ.push_back(a);
    for (int i = 0; i <= len; i++) begin
      logic [3:0] ad;
      ad = a + 4'(i);
      if (wr) begin
        logic [3:0] v;
        v = (i[0] ? d1 : d0) ^ 4'(i);
        wrQ.push_back(v);
        if (ad < 4'd10) shadow[ad] = v;
      end else begin
        rdQ.push_back(expVal(ad));
      end
    end
    @(negedge clk);
    cmdAddr = a; cmdLen = len; cmdWrite = wr; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    int l0, r0, w0, k0, rc0;
    rst = 1'b1; cmdValid = 1'b0; cmdAddr = 0; cmdLen = 0; cmdWrite = 0;
    keysNext = 7'h7F;
    for (int i = 0; i < 10; i++) shadow[i] = 4'h0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ldaN && rdN && wrN, "R1", "strobes in reset", {ldaN, rdN, wrN}, 7);
    chk(!busy, "R1", "busy in reset", busy, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(ldaN && rdN && wrN && !busy, "R1", "idle after reset", {ldaN, rdN, wrN, busy}, 14);
    chk(cmdReady, "R1", "ready after reset", cmdReady, 1);

    // write burst of 6 at 0
    l0 = ldaFalls; w0 = wrFalls;
    doCmd(4'h0, 4'd5, 1, 4'h3, 4'hC);
    chk(busy, "R7", "busy after accept", busy, 1);
    waitIdle();
    chk(ldaFalls - l0 == 1, "R5", "address phases in write burst", ldaFalls - l0, 1);
    chk(wrFalls - w0 == 6, "R5", "write strobes in burst", wrFalls - w0, 6);

    // read back the same 6
    l0 = ldaFalls; rc0 = rdCount;
    doCmd(4'h0, 4'd5, 0);
    waitIdle();
    chk(rdCount - rc0 == 6, "R4", "read pulses", rdCount - rc0, 6);
    chk(ldaFalls - l0 == 1, "R5", "address phases in read burst", ldaFalls - l0, 1);

    // stalled single write at 7
    wrStall = 1'b1;
    w0 = wrFalls;
    doCmd(4'h7, 4'd0, 1, 4'hE, 4'h0);
    repeat (12) @(negedge clk);
    chk(wrFalls == w0, "R3", "no strobe while stalled", wrFalls - w0, 0);
    chk(busy && !cmdReady, "R7", "busy and not ready while stalled", {busy, cmdReady}, 2);
    wrStall = 1'b0;
    waitIdle();
    chk(wrFalls - w0 == 1, "R3", "strobe after stall", wrFalls - w0, 1);
    rc0 = rdCount;
    doCmd(4'h7, 4'd0, 0);
    waitIdle();
    chk(rdCount - rc0 == 1, "R3", "readback of stalled write", rdCount - rc0, 1);

    // 16-nibble read from 8, wrapping
    l0 = ldaFalls; rc0 = rdCount;
    doCmd(4'h8, 4'd15, 0);
    waitIdle();
    chk(rdCount - rc0 == 16, "R5", "sixteen nibble burst", rdCount - rc0, 16);
    chk(ldaFalls - l0 == 1, "R5", "single address for 16", ldaFalls - l0, 1);

    // key change while idle
    k0 = keyCount; rc0 = rdCount; l0 = ldaFalls; r0 = rdFalls;
    ldaQ.push_back(4'hA);
    @(negedge clk); keysNext = 7'h5A;
    @(negedge clk);
    chk(!intrN && !cmdReady, "R7", "not ready while interrupt low", {intrN, cmdReady}, 0);
    @(negedge clk);
    waitIdle();
    chk(keyCount - k0 == 1, "R8", "key pulses", keyCount - k0, 1);
    chk(rdCount == rc0, "R8", "no read pulse during service", rdCount - rc0, 0);
    chk(rdFalls - r0 == 2 && ldaFalls - l0 == 1, "R8", "service strobes",
        (rdFalls - r0) * 16 + (ldaFalls - l0), 33);
    chk(intrN, "R8", "interrupt released", intrN, 1);

    // key change during a burst
    rc0 = rdCount; k0 = keyCount;
    doCmd(4'h0, 4'd7, 0);
    repeat (10) @(negedge clk);
    ldaQ.push_back(4'hA);
    keysNext = 7'h33;
    doCmd(4'h2, 4'd1, 0);
    waitIdle();
    chk(keyCount - k0 == 1, "R9", "service after burst", keyCount - k0, 1);
    chk(keyAtRd - rc0 == 8, "R9", "reads before key pulse", keyAtRd - rc0, 8);
    chk(rdCount - rc0 == 10, "R9", "reads in total", rdCount - rc0, 10);
    chk(ldaQ.size() == 0 && rdQ.size() == 0, "R9", "pending expectations",
        ldaQ.size() + rdQ.size(), 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule